// File: doc/BRIEF.md
# Range-Checked Word Data Memory

This block is the data store of a small 64-bit processor model. It holds a flat byte array whose size is a parameter and moves exactly eight bytes per access. Bytes are packed little-endian: the byte at the presented address is the least significant byte of the word. The address does not need to be aligned. Reads are combinational and writes take effect on the rising clock edge.

Every access is checked against the top of the implemented array. A word that would run past the last byte raises an error flag on both the read path and the write path. A write that fails the check changes nothing, and a read that fails it returns zero. The processor uses the flag to stop with an address fault.

Top module: `dmem_word_store`

## Requirements
- R1: After synchronous reset, every valid word reads as zero.
- R2: With the read enable high, the write enable low and a valid address, the read datum shows the eight stored bytes at that address in the same cycle, with no clock edge in between.
- R3: With the read enable low, the read datum is zero.
- R4: With the write enable high and a valid address, the word is stored on the rising clock edge and can be read from the next cycle on. This holds up to the highest valid address.
- R5: Byte order is little-endian. Byte address A+k holds bits [8k+7:8k] of the word, for k from 0 to 7. Addresses need not be multiples of 8, and words written at overlapping addresses share bytes.
- R6: An address is valid when it is at most MEM_BYTES-8, so that address+7 is the last byte or below. With either enable high and an invalid address, the error output is 1. This includes addresses near the top of the 64-bit range, where address+7 would wrap.
- R7: With both enables low, the error output is 0.
- R8: A write whose address is invalid modifies no byte of the array.
- R9: A read with the error output at 1 returns a read datum of zero.
- R10: Read enable and write enable are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the array |
| addr | input | ADDR_W | Byte address of the lowest byte of the word |
| wdata | input | 64 | Word to store |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| rdata | output | 64 | Word read, little-endian |
| err | output | 1 | Address out of range for the current access |

## Verification
The bench builds the block with a 64-byte array and a 64-bit address. With this size it can read every byte address in the array and a band beyond it, including the boundary start address 56 and the straddling starts 57 to 63. It also writes every aligned word, writes at unaligned offsets, and attempts writes at addresses near the top of the 64-bit range. After each group of faulting writes, it reads back the whole array and compares it with a byte model kept in the bench.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    localparam int unsigned WORD_BYTES = 8;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned WORD_W     = WORD_BYTES * BYTE_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Kind of access presented this cycle
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_CLASH = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      in_range;
    } acc_info_t;

    function automatic acc_kind_e classify(input logic rd, input logic wr);
        acc_kind_e k;
        case ({wr, rd})
            2'b01:   k = ACC_READ;
            2'b10:   k = ACC_WRITE;
            2'b11:   k = ACC_CLASH;
            default: k = ACC_IDLE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/dmem_range_check.sv
module dmem_range_check
    import dmem_pkg::*;
#(
    parameter int unsigned ADDR_W    = 64,
    parameter int unsigned MEM_BYTES = 1024
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    output acc_info_t         info,
    output logic              err
);

    // Highest start address whose eight bytes all fit in the array
    localparam logic [ADDR_W-1:0] LAST_START = ADDR_W'(MEM_BYTES - WORD_BYTES);

    always_comb begin
        info.kind     = classify(rd_en, wr_en);
        // Compare the start address, so no address+7 sum can wrap
        info.in_range = (addr <= LAST_START);
        err           = (info.kind != ACC_IDLE) && !info.in_range;
    end

endmodule

// File: rtl/dmem_byte_store.sv
module dmem_byte_store
    import dmem_pkg::*;
#(
    parameter int unsigned MEM_BYTES = 1024,
    localparam int unsigned IDX_W    = $clog2(MEM_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_go,
    input  logic [IDX_W-1:0] idx,
    input  word_t            wdata,
    output word_t            rword
);

    byte_t mem [MEM_BYTES];

    // Lane k of the word sits at byte idx+k (little-endian)
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(MEM_BYTES); i++) begin
                mem[i] <= '0;
            end
        end else if (wr_go) begin
            for (int k = 0; k < int'(WORD_BYTES); k++) begin
                mem[idx + IDX_W'(k)] <= wdata[BYTE_W*k +: BYTE_W];
            end
        end
    end

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        assign rword[BYTE_W*g +: BYTE_W] = mem[idx + IDX_W'(g)];
    end

endmodule

// File: rtl/dmem_word_store.sv
module dmem_word_store
    import dmem_pkg::*;
#(
    parameter int unsigned ADDR_W    = 64,
    parameter int unsigned MEM_BYTES = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [63:0]       wdata,
    input  logic              rd_en,
    input  logic              wr_en,
    output logic [63:0]       rdata,
    output logic              err
);

    localparam int unsigned        IDX_W      = $clog2(MEM_BYTES);
    localparam logic [ADDR_W-1:0] LAST_START = ADDR_W'(MEM_BYTES - WORD_BYTES);

    acc_info_t        info;
    logic             wr_go;
    logic [IDX_W-1:0] idx;
    word_t            rword;

    assign idx   = addr[IDX_W-1:0];
    assign wr_go = (info.kind == ACC_WRITE) && info.in_range;

    dmem_range_check #(
        .ADDR_W   (ADDR_W),
        .MEM_BYTES(MEM_BYTES)
    ) u_range (
        .addr (addr),
        .rd_en(rd_en),
        .wr_en(wr_en),
        .info (info),
        .err  (err)
    );

    dmem_byte_store #(
        .MEM_BYTES(MEM_BYTES)
    ) u_store (
        .clk  (clk),
        .rst  (rst),
        .wr_go(wr_go),
        .idx  (idx),
        .wdata(wdata),
        .rword(rword)
    );

    always_comb begin
        if ((info.kind == ACC_READ) && info.in_range) rdata = rword;
        else                                          rdata = '0;
    end

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en)); // R10

    AST_ERR_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst)
        ((rd_en || wr_en) && (addr > LAST_START)) |-> err); // R6

    AST_ERR_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !wr_en) |-> !err); // R7

    AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        err |-> (rdata == '0)); // R9

    AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rdata == '0)); // R3

    AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en && !err) && rd_en && (addr == $past(addr)))
            |-> (rdata == $past(wdata))); // R4

endmodule

// File: tb/tb_dmem_word_store.sv
module tb_dmem_word_store;

    localparam int unsigned ADDR_W = 64;
    localparam int unsigned MEMB   = 64;
    localparam int unsigned LASTS  = MEMB - 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [63:0]       wdata = '0;
    logic              rd_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [63:0]       rdata;
    logic              err;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [MEMB];

    always #2.5 clk = ~clk;

    dmem_word_store #(.ADDR_W(ADDR_W), .MEM_BYTES(MEMB)) dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .rd_en(rd_en), .wr_en(wr_en), .rdata(rdata), .err(err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model_word(input logic [ADDR_W-1:0] a);
        logic [63:0] w = '0;
        for (int k = 0; k < 8; k++) w[8*k +: 8] = model[a + ADDR_W'(k)];
        return w;
    endfunction

    function automatic logic is_valid(input logic [ADDR_W-1:0] a);
        return a <= ADDR_W'(LASTS);
    endfunction

    task automatic do_read(input logic [ADDR_W-1:0] a, input string req);
        @(negedge clk);
        addr = a; rd_en = 1'b1; wr_en = 1'b0;
        #1;
        chk("R10", 64'(rd_en && wr_en), 64'd0);
        if (is_valid(a)) begin
            chk(req, rdata, model_word(a));
            chk("R6", 64'(err), 64'd0);
        end else begin
            chk("R6", 64'(err), 64'd1);
            chk("R9", rdata, 64'd0);
        end
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [63:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        #1;
        chk("R6", 64'(err), 64'(!is_valid(a)));
        chk("R3", rdata, 64'd0);
        @(negedge clk);
        wr_en = 1'b0;
        if (is_valid(a))
            for (int k = 0; k < 8; k++) model[a + ADDR_W'(k)] = d[8*k +: 8];
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < int'(MEMB); i++) model[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: cleared after reset
        for (int a = 0; a <= int'(LASTS); a++) do_read(ADDR_W'(a), "R1");

        // R7, R3: idle cycle
        @(negedge clk);
        addr = ADDR_W'(70); rd_en = 1'b0; wr_en = 1'b0;
        #1;
        chk("R7", 64'(err), 64'd0);
        chk("R3", rdata, 64'd0);

        // R4: aligned words everywhere, including the boundary start
        for (int a = 0; a <= int'(LASTS); a += 8) begin
            logic [63:0] d;
            for (int k = 0; k < 8; k++) d[8*k +: 8] = 8'(a * 8 + k * 3 + 17);
            do_write(ADDR_W'(a), d);
            do_read(ADDR_W'(a), "R4");
        end

        // R2, R5, R6, R9: every byte start and a band past the top
        for (int a = 0; a < int'(MEMB) + 10; a++) do_read(ADDR_W'(a), "R2");

        // R5: explicit byte order
        do_write(ADDR_W'(8), 64'h8877_6655_4433_2211);
        do_read(ADDR_W'(9), "R5");
        chk("R5", 64'(rdata[7:0]), 64'h22);
        do_write(ADDR_W'(3), 64'hA1B2_C3D4_E5F6_0718);
        do_read(ADDR_W'(0), "R5");
        do_read(ADDR_W'(8), "R5");

        // R6, R8: faulting writes leave the array untouched
        do_write(ADDR_W'(57), 64'hDEAD_BEEF_0000_0001);
        do_write(ADDR_W'(63), 64'hDEAD_BEEF_0000_0002);
        do_write(ADDR_W'(64), 64'hDEAD_BEEF_0000_0003);
        do_write(ADDR_W'(200), 64'hDEAD_BEEF_0000_0004);
        do_write(64'hFFFF_FFFF_FFFF_FFFC, 64'hDEAD_BEEF_0000_0005);
        do_write(64'hFFFF_FFFF_FFFF_FFF8, 64'hDEAD_BEEF_0000_0006);
        for (int a = 0; a <= int'(LASTS); a++) do_read(ADDR_W'(a), "R8");
        do_read(64'hFFFF_FFFF_FFFF_FFFC, "R6");

        // R4: boundary word written and read back
        do_write(ADDR_W'(LASTS), 64'h0123_4567_89AB_CDEF);
        do_read(ADDR_W'(LASTS), "R4");

        // R3: read enable low at a valid, written address
        @(negedge clk);
        addr = ADDR_W'(LASTS); rd_en = 1'b0;
        #1;
        chk("R3", rdata, 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule